// File: doc/BRIEF.md
# Three-Wire Serial Command Decoder

This block takes configuration commands from a host over a three-wire serial port: an active-low select, a serial clock and one data line. It brings the three wires into the system clock domain and detects the serial clock's rising edges. It then collects the data line into bytes and reads the first byte of each select window as a command header.

The low two bits of a header name a target device. A window whose header carries another device's ID is skipped to its end. A window with an accepted header is handled as one of four things:

- a run of per-channel control word pairs;
- a run of per-channel conference word pairs;
- a stream of seven-byte slot records, ended by a footer byte;
- a power-up or power-down request, which the block turns into a one-cycle pulse.

Downstream logic reads the stored words through a combinational read port indexed by channel. The two pair commands start at a channel given in the second byte and write consecutive channels from there. The slot record stream always fills entries starting at entry 0. A record is committed only once all seven of its bytes have arrived.

Top module: `serial_cmd_decoder`

The decoder state machine has six states, and the header state is entered whenever the select window closes:

| State | Role | Transition on the next received byte |
|---|---|---|
| `ST_HDR` | wait for a header byte | to `ST_BEGIN` for a control or conference header; to `ST_REC` for a slot header; to `ST_SKIP` for a power request, an ID mismatch or an unknown opcode |
| `ST_BEGIN` | take the start channel | to `ST_PAIR_HI` |
| `ST_PAIR_HI` | hold the high byte | to `ST_PAIR_LO` |
| `ST_PAIR_LO` | write the word | back to `ST_PAIR_HI` |
| `ST_REC` | collect record bytes | to `ST_SKIP` on the footer byte 0xFF in lane 0; otherwise stays in `ST_REC` |
| `ST_SKIP` | ignore the rest of the window | stays in `ST_SKIP` |

## Requirements
- R1: While `ser_sel_n` is low, the block samples `ser_dat` on each rising edge of `ser_clk`. Bits are taken least significant first, and every eight of them form one byte.
- R2: If `ser_sel_n` goes high part-way through a byte, that partial byte is dropped and has no effect. The decoder goes back to `ST_HDR`, and the next window starts with a fresh header.
- R3: A header whose bits [1:0] differ from `chip_id` causes the whole window to be ignored. This includes power requests.
- R4: Header `0x30|ID` selects control pairs. The next byte is the start channel, and each following pair of bytes (high byte, then low byte) writes the word `{high,low}` into consecutive channel slots.
- R5: Header `0x20|ID` selects conference pairs. The framing is the same as R4, and the words are written into the conference words.
- R6: Pairs aimed at a channel at or above `NCH` are dropped. This covers every pair when the start channel byte is itself `NCH` or larger; such a byte is not wrapped.
- R7: Header `0x00|ID` selects slot records of seven bytes each, written to entries 0, 1, 2 and so on. Byte k of a record lands at bits [8k+7:8k] of the 56-bit entry. A record is committed only when its seventh byte arrives, so a record cut short by the end of the window leaves its entry unchanged.
- R8: In a slot stream, a byte 0xFF in the first-byte position of a record ends the stream. The remaining bytes of the window change nothing.
- R9: Header `0x08|ID` produces a single one-cycle pulse on `pwr_up_pulse`, and header `0x10|ID` produces one on `pwr_dn_pulse`. The two pulses are never high together.
- R10: After reset, every control word reads 0x3670: stepsize field [14:13]=01, comfort noise field [12:11]=10, DC remover bit 10, NLP bit 9, tone detect bit 6, echo canceller reset bit 5 and ADPCM reset bit 4. Every conference word and every slot entry reads 0 after reset.
- R11: A header with a matching ID but an opcode in bits [7:2] other than 0x00, 0x02, 0x04, 0x08 or 0x0C is ignored together with the rest of its window.
- R12: `rd_ctrl`, `rd_conf` and `rd_slot` show the entry selected by `rd_idx` in the same cycle. They change only when that entry is written or `rd_idx` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Serial window select, active low, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, least significant bit first |
| chip_id | input | 2 | Strapped device ID compared with header bits [1:0] |
| rd_idx | input | CHW | Channel / entry index for the read port |
| rd_ctrl | output | 16 | Control word of the indexed channel |
| rd_conf | output | 16 | Conference word of the indexed channel |
| rd_slot | output | 56 | Slot record of the indexed entry |
| pwr_up_pulse | output | 1 | One-cycle power-up request |
| pwr_dn_pulse | output | 1 | One-cycle power-down request |

## Verification
The checker watches several properties on every cycle:
- a completed byte only follows a cycle in which the window was open;
- every window end leaves the state machine in `ST_HDR` on the next cycle;
- the two power pulses are exclusive and last one cycle;
- the read outputs hold steady while no write occurs and the index stays put.

The data-dependent behaviour can only be shown by the directed scenarios. This covers bit order, the pair and record framing, dropping of out-of-range channels, the footer, rejection of another device's ID or an unknown opcode, partial-byte and partial-record discard, and the reset defaults.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;

    localparam int BYTE_W    = 8;
    localparam int REC_BYTES = 7;
    localparam int REC_W     = REC_BYTES * BYTE_W;
    localparam int WORD_W    = 2 * BYTE_W;

    // Opcodes carried in header bits [7:2]
    localparam logic [5:0] OP_SLOT  = 6'h00;
    localparam logic [5:0] OP_PWRUP = 6'h02;
    localparam logic [5:0] OP_PWRDN = 6'h04;
    localparam logic [5:0] OP_CONF  = 6'h08;
    localparam logic [5:0] OP_CTRL  = 6'h0C;

    localparam logic [BYTE_W-1:0] REC_FOOTER = 8'hFF;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_BEGIN,
        ST_PAIR_HI,
        ST_PAIR_LO,
        ST_REC,
        ST_SKIP
    } dec_state_t;

    typedef enum logic {
        TGT_CTRL,
        TGT_CONF
    } pair_tgt_t;

endpackage

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import serial_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sck_i,
    input  logic              sd_i,
    output logic [BYTE_W-1:0] bval_o,
    output logic              bval_vld_o,
    output logic              win_act_o,
    output logic              win_end_o
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [2:0]        sel_q;
    logic [2:0]        sck_q;
    logic [1:0]        sd_q;
    logic [BYTE_W-1:0] shift_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              sck_rise;
    logic              last_bit;

    // Two-flop synchronizers plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '1;
            sck_q <= '0;
            sd_q  <= '0;
        end else begin
            sel_q <= {sel_q[1:0], sel_n_i};
            sck_q <= {sck_q[1:0], sck_i};
            sd_q  <= {sd_q[0], sd_i};
        end
    end

    assign win_act_o = ~sel_q[1];
    assign win_end_o = sel_q[1] & ~sel_q[2];
    assign sck_rise  = sck_q[1] & ~sck_q[2];
    assign last_bit  = (bit_cnt_q == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            bit_cnt_q  <= '0;
            bval_o     <= '0;
            bval_vld_o <= 1'b0;
        end else begin
            bval_vld_o <= 1'b0;
            if (!win_act_o) begin
                bit_cnt_q <= '0;
            end else if (sck_rise) begin
                shift_q   <= {sd_q[1], shift_q[BYTE_W-1:1]};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (last_bit) begin
                    bval_o     <= {sd_q[1], shift_q[BYTE_W-1:1]};
                    bval_vld_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_cmd_dec.sv
module serial_cmd_dec
    import serial_cmd_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        id_i,
    input  logic [BYTE_W-1:0] bval_i,
    input  logic              bval_vld_i,
    input  logic              win_end_i,
    output logic              ctrl_we_o,
    output logic              conf_we_o,
    output logic [CHW-1:0]    pair_idx_o,
    output logic [WORD_W-1:0] pair_data_o,
    output logic              rec_we_o,
    output logic [CHW-1:0]    rec_idx_o,
    output logic [REC_W-1:0]  rec_data_o,
    output logic              pwr_up_o,
    output logic              pwr_dn_o,
    output dec_state_t        state_o
);

    localparam int               STG_W  = REC_W - BYTE_W;
    localparam logic [BYTE_W-1:0] NCH_B = BYTE_W'(NCH);
    localparam logic [CHW:0]      NCH_C = (CHW+1)'(NCH);
    localparam logic [2:0]        LAST_LANE = 3'(REC_BYTES - 1);

    dec_state_t        state_q, state_d;
    pair_tgt_t         tgt_q;
    logic [CHW:0]      chan_q;
    logic [CHW:0]      rec_cnt_q;
    logic [BYTE_W-1:0] hi_q;
    logic [2:0]        lane_q;
    logic [STG_W-1:0]  stage_q;
    logic              id_ok;
    logic [5:0]        opc;

    assign id_ok = (bval_i[1:0] == id_i);
    assign opc   = bval_i[7:2];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HDR;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (win_end_i) begin
            state_d = ST_HDR;
        end else if (bval_vld_i) begin
            unique case (state_q)
                ST_HDR: begin
                    if (!id_ok)                                state_d = ST_SKIP;
                    else if (opc == OP_CTRL || opc == OP_CONF) state_d = ST_BEGIN;
                    else if (opc == OP_SLOT)                   state_d = ST_REC;
                    else                                       state_d = ST_SKIP;
                end
                ST_BEGIN:   state_d = ST_PAIR_HI;
                ST_PAIR_HI: state_d = ST_PAIR_LO;
                ST_PAIR_LO: state_d = ST_PAIR_HI;
                ST_REC: begin
                    if (lane_q == 3'd0 && bval_i == REC_FOOTER) state_d = ST_SKIP;
                end
                ST_SKIP:    state_d = ST_SKIP;
                default:    state_d = ST_HDR;
            endcase
        end
    end

    // Datapath held across bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q     <= TGT_CTRL;
            chan_q    <= '0;
            rec_cnt_q <= '0;
            hi_q      <= '0;
            lane_q    <= '0;
            stage_q   <= '0;
        end else if (bval_vld_i) begin
            unique case (state_q)
                ST_HDR: begin
                    tgt_q     <= (opc == OP_CONF) ? TGT_CONF : TGT_CTRL;
                    rec_cnt_q <= '0;
                    lane_q    <= '0;
                end
                ST_BEGIN:   chan_q <= (bval_i >= NCH_B) ? NCH_C : bval_i[CHW:0];
                ST_PAIR_HI: hi_q   <= bval_i;
                ST_PAIR_LO: begin
                    if (chan_q < NCH_C) chan_q <= chan_q + 1'b1;
                end
                ST_REC: begin
                    if (lane_q == LAST_LANE) begin
                        lane_q <= '0;
                        if (rec_cnt_q < NCH_C) rec_cnt_q <= rec_cnt_q + 1'b1;
                    end else if (!(lane_q == 3'd0 && bval_i == REC_FOOTER)) begin
                        stage_q[lane_q*BYTE_W +: BYTE_W] <= bval_i;
                        lane_q <= lane_q + 1'b1;
                    end
                end
                ST_SKIP: ;
                default: ;
            endcase
        end
    end

    // Write-side outputs
    always_comb begin
        ctrl_we_o   = 1'b0;
        conf_we_o   = 1'b0;
        rec_we_o    = 1'b0;
        pair_idx_o  = chan_q[CHW-1:0];
        pair_data_o = {hi_q, bval_i};
        rec_idx_o   = rec_cnt_q[CHW-1:0];
        rec_data_o  = {bval_i, stage_q};
        if (bval_vld_i) begin
            unique case (state_q)
                ST_PAIR_LO: begin
                    if (chan_q < NCH_C) begin
                        ctrl_we_o = (tgt_q == TGT_CTRL);
                        conf_we_o = (tgt_q == TGT_CONF);
                    end
                end
                ST_REC:   rec_we_o = (lane_q == LAST_LANE) && (rec_cnt_q < NCH_C);
                default: ;
            endcase
        end
    end

    // Registered power request pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_up_o <= 1'b0;
            pwr_dn_o <= 1'b0;
        end else begin
            pwr_up_o <= bval_vld_i && (state_q == ST_HDR) && id_ok && (opc == OP_PWRUP);
            pwr_dn_o <= bval_vld_i && (state_q == ST_HDR) && id_ok && (opc == OP_PWRDN);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/serial_cmd_regs.sv
module serial_cmd_regs
    import serial_cmd_pkg::*;
#(
    parameter int              NCH      = 8,
    parameter int              CHW      = $clog2(NCH),
    parameter logic [WORD_W-1:0] CTRL_RST = 16'h3670
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we_i,
    input  logic              conf_we_i,
    input  logic [CHW-1:0]    pair_idx_i,
    input  logic [WORD_W-1:0] pair_data_i,
    input  logic              rec_we_i,
    input  logic [CHW-1:0]    rec_idx_i,
    input  logic [REC_W-1:0]  rec_data_i,
    input  logic [CHW-1:0]    rd_idx_i,
    output logic [WORD_W-1:0] rd_ctrl_o,
    output logic [WORD_W-1:0] rd_conf_o,
    output logic [REC_W-1:0]  rd_slot_o
);

    logic [WORD_W-1:0] ctrl_all [NCH];
    logic [WORD_W-1:0] conf_all [NCH];
    logic [REC_W-1:0]  slot_all [NCH];

    for (genvar e = 0; e < NCH; e++) begin : g_ent
        logic [WORD_W-1:0] ctrl_q;
        logic [WORD_W-1:0] conf_q;
        logic [REC_W-1:0]  slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q <= CTRL_RST;
                conf_q <= '0;
                slot_q <= '0;
            end else begin
                if (ctrl_we_i && pair_idx_i == CHW'(e)) ctrl_q <= pair_data_i;
                if (conf_we_i && pair_idx_i == CHW'(e)) conf_q <= pair_data_i;
                if (rec_we_i  && rec_idx_i  == CHW'(e)) slot_q <= rec_data_i;
            end
        end

        assign ctrl_all[e] = ctrl_q;
        assign conf_all[e] = conf_q;
        assign slot_all[e] = slot_q;
    end

    assign rd_ctrl_o = ctrl_all[rd_idx_i];
    assign rd_conf_o = conf_all[rd_idx_i];
    assign rd_slot_o = slot_all[rd_idx_i];

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import serial_cmd_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic [1:0]        chip_id,
    input  logic [CHW-1:0]    rd_idx,
    output logic [WORD_W-1:0] rd_ctrl,
    output logic [WORD_W-1:0] rd_conf,
    output logic [REC_W-1:0]  rd_slot,
    output logic              pwr_up_pulse,
    output logic              pwr_dn_pulse
);

    logic [BYTE_W-1:0] bval;
    logic              bval_vld;
    logic              win_act;
    logic              win_end;
    logic              ctrl_we;
    logic              conf_we;
    logic [CHW-1:0]    pair_idx;
    logic [WORD_W-1:0] pair_data;
    logic              rec_we;
    logic [CHW-1:0]    rec_idx;
    logic [REC_W-1:0]  rec_data;
    dec_state_t        dec_state;

    serial_cmd_rx i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_i    (ser_sel_n),
        .sck_i      (ser_clk),
        .sd_i       (ser_dat),
        .bval_o     (bval),
        .bval_vld_o (bval_vld),
        .win_act_o  (win_act),
        .win_end_o  (win_end)
    );

    serial_cmd_dec #(.NCH(NCH), .CHW(CHW)) i_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_i        (chip_id),
        .bval_i      (bval),
        .bval_vld_i  (bval_vld),
        .win_end_i   (win_end),
        .ctrl_we_o   (ctrl_we),
        .conf_we_o   (conf_we),
        .pair_idx_o  (pair_idx),
        .pair_data_o (pair_data),
        .rec_we_o    (rec_we),
        .rec_idx_o   (rec_idx),
        .rec_data_o  (rec_data),
        .pwr_up_o    (pwr_up_pulse),
        .pwr_dn_o    (pwr_dn_pulse),
        .state_o     (dec_state)
    );

    serial_cmd_regs #(.NCH(NCH), .CHW(CHW)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we_i   (ctrl_we),
        .conf_we_i   (conf_we),
        .pair_idx_i  (pair_idx),
        .pair_data_i (pair_data),
        .rec_we_i    (rec_we),
        .rec_idx_i   (rec_idx),
        .rec_data_i  (rec_data),
        .rd_idx_i    (rd_idx),
        .rd_ctrl_o   (rd_ctrl),
        .rd_conf_o   (rd_conf),
        .rd_slot_o   (rd_slot)
    );

endmodule

// File: rtl/serial_cmd_decoder_chk.sv
module serial_cmd_decoder_chk
    import serial_cmd_pkg::*;
#(
    parameter int CHW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_act,
    input logic              win_end,
    input logic              bval_vld,
    input dec_state_t        dec_state,
    input logic              ctrl_we,
    input logic              conf_we,
    input logic              rec_we,
    input logic [CHW-1:0]    rd_idx,
    input logic [WORD_W-1:0] rd_ctrl,
    input logic [WORD_W-1:0] rd_conf,
    input logic [REC_W-1:0]  rd_slot,
    input logic              pwr_up_pulse,
    input logic              pwr_dn_pulse
);

    // R1: a completed byte only follows a cycle with the window open
    a_r1_byte_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        bval_vld |-> $past(win_act));

    // R2: closing the window always returns the decoder to the header state
    a_r2_end_to_header: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (dec_state == ST_HDR));

    // R9: power pulses are exclusive
    a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pwr_up_pulse, pwr_dn_pulse}));

    // R9: each power pulse lasts one cycle
    a_r9_up_single: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up_pulse |=> !pwr_up_pulse);

    a_r9_dn_single: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_pulse |=> !pwr_dn_pulse);

    // R12: read outputs hold when nothing is written and the index stays
    a_r12_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_we || conf_we || rec_we) |=>
            (rd_idx != $past(rd_idx)) ||
            (rd_ctrl == $past(rd_ctrl) && rd_conf == $past(rd_conf) &&
             rd_slot == $past(rd_slot)));

endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk #(.CHW(CHW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_act      (win_act),
    .win_end      (win_end),
    .bval_vld     (bval_vld),
    .dec_state    (dec_state),
    .ctrl_we      (ctrl_we),
    .conf_we      (conf_we),
    .rec_we       (rec_we),
    .rd_idx       (rd_idx),
    .rd_ctrl      (rd_ctrl),
    .rd_conf      (rd_conf),
    .rd_slot      (rd_slot),
    .pwr_up_pulse (pwr_up_pulse),
    .pwr_dn_pulse (pwr_dn_pulse)
);

// File: tb/test_serial_cmd_decoder.sv
module test_serial_cmd_decoder;

    localparam int NCH = 8;
    localparam int CHW = 3;
    localparam logic [1:0] MY_ID = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_sel_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic [1:0]  chip_id = MY_ID;
    logic [CHW-1:0] rd_idx = '0;
    logic [15:0] rd_ctrl;
    logic [15:0] rd_conf;
    logic [55:0] rd_slot;
    logic        pwr_up_pulse;
    logic        pwr_dn_pulse;

    int errors = 0;
    int checks = 0;
    int up_cnt = 0;
    int dn_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_cmd_decoder #(.NCH(NCH), .CHW(CHW)) i_serial_cmd_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_sel_n    (ser_sel_n),
        .ser_clk      (ser_clk),
        .ser_dat      (ser_dat),
        .chip_id      (chip_id),
        .rd_idx       (rd_idx),
        .rd_ctrl      (rd_ctrl),
        .rd_conf      (rd_conf),
        .rd_slot      (rd_slot),
        .pwr_up_pulse (pwr_up_pulse),
        .pwr_dn_pulse (pwr_dn_pulse)
    );

    always @(posedge clk) begin
        if (pwr_up_pulse) up_cnt <= up_cnt + 1;
        if (pwr_dn_pulse) dn_cnt <= dn_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = b[i];
            ser_clk = 1'b0;
            tick(4);
            ser_clk = 1'b1;
            tick(4);
        end
        ser_clk = 1'b0;
        tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic open_win();
        ser_clk = 1'b0;
        ser_sel_n = 1'b0;
        tick(4);
    endtask

    task automatic close_win();
        ser_clk = 1'b0;
        tick(2);
        ser_sel_n = 1'b1;
        tick(10);
    endtask

    task automatic rd(input int idx);
        @(negedge clk);
        rd_idx = CHW'(idx);
        #1;
    endtask

    task automatic t_reset();
        for (int c = 0; c < NCH; c++) begin
            rd(c);
            chk("R10 ctrl default", 64'(rd_ctrl), 64'h3670);
            chk("R10 conf default", 64'(rd_conf), 64'h0);
            chk("R10 slot default", 64'(rd_slot), 64'h0);
        end
        chk("R9 no pulse after reset", 64'(up_cnt + dn_cnt), 64'd0);
    endtask

    task automatic t_ctrl_pairs();
        open_win();
        send_byte(8'h32); send_byte(8'h02);
        send_byte(8'h12); send_byte(8'h34);
        send_byte(8'hAB); send_byte(8'hCD);
        close_win();
        rd(2); chk("R4 R1 ctrl ch2", 64'(rd_ctrl), 64'h1234);
        rd(3); chk("R4 ctrl ch3", 64'(rd_ctrl), 64'hABCD);
        rd(1); chk("R4 ctrl ch1 untouched", 64'(rd_ctrl), 64'h3670);
        rd(4); chk("R4 ctrl ch4 untouched", 64'(rd_ctrl), 64'h3670);
        rd(2); chk("R5 conf ch2 untouched by ctrl", 64'(rd_conf), 64'h0);
    endtask

    task automatic t_conf_pairs();
        open_win();
        send_byte(8'h22); send_byte(8'h06);
        send_byte(8'h30); send_byte(8'h14);
        send_byte(8'h34); send_byte(8'h56);
        send_byte(8'h99); send_byte(8'h99);
        close_win();
        rd(6); chk("R5 conf ch6", 64'(rd_conf), 64'h3014);
        rd(7); chk("R5 conf ch7", 64'(rd_conf), 64'h3456);
        rd(0); chk("R6 pair past last channel dropped", 64'(rd_conf), 64'h0);
        rd(6); chk("R5 ctrl ch6 untouched by conf", 64'(rd_ctrl), 64'h3670);
        open_win();
        send_byte(8'h22); send_byte(8'h09);
        send_byte(8'h11); send_byte(8'h11);
        close_win();
        rd(1); chk("R6 start channel 9 not wrapped", 64'(rd_conf), 64'h0);
        rd(6); chk("R6 conf ch6 kept", 64'(rd_conf), 64'h3014);
    endtask

    task automatic t_wrong_id_unknown();
        open_win();
        send_byte(8'h33); send_byte(8'h00);
        send_byte(8'hDE); send_byte(8'hAD);
        close_win();
        rd(0); chk("R3 foreign ID ignored", 64'(rd_ctrl), 64'h3670);
        open_win();
        send_byte(8'h42); send_byte(8'h32); send_byte(8'h00);
        send_byte(8'hBE); send_byte(8'hEF);
        close_win();
        rd(0); chk("R11 unknown opcode window ignored ctrl", 64'(rd_ctrl), 64'h3670);
        rd(1); chk("R11 unknown opcode window ignored conf", 64'(rd_conf), 64'h0);
    endtask

    task automatic t_abort();
        open_win();
        send_byte(8'h32); send_byte(8'h00); send_byte(8'h55);
        send_bits(8'h07, 3);
        close_win();
        rd(0); chk("R2 half pair with partial byte no write", 64'(rd_ctrl), 64'h3670);
        open_win();
        send_bits(8'h1F, 5);
        close_win();
        open_win();
        send_byte(8'h32); send_byte(8'h01);
        send_byte(8'h0F); send_byte(8'h0F);
        close_win();
        rd(1); chk("R2 fresh header after abort", 64'(rd_ctrl), 64'h0F0F);
        rd(0); chk("R2 ch0 unchanged after abort", 64'(rd_ctrl), 64'h3670);
    endtask

    task automatic t_slots();
        open_win();
        send_byte(8'h02);
        send_byte(8'hD0); send_byte(8'h5E); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h03); send_byte(8'h00); send_byte(8'h07);
        send_byte(8'h10); send_byte(8'h1E); send_byte(8'h08); send_byte(8'h00);
        send_byte(8'h07); send_byte(8'h00); send_byte(8'h03);
        send_byte(8'hFF);
        for (int k = 1; k <= 7; k++) send_byte(8'(k));
        close_win();
        rd(0); chk("R7 slot entry0", 64'(rd_slot), 64'h07_00_03_00_00_5E_D0);
        rd(1); chk("R7 slot entry1", 64'(rd_slot), 64'h03_00_07_00_08_1E_10);
        rd(2); chk("R8 bytes after footer ignored", 64'(rd_slot), 64'h0);
        open_win();
        send_byte(8'h02);
        send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
        close_win();
        rd(0); chk("R7 short record not committed", 64'(rd_slot), 64'h07_00_03_00_00_5E_D0);
    endtask

    task automatic t_power();
        open_win(); send_byte(8'h0A); close_win();
        chk("R9 power-up pulse count", 64'(up_cnt), 64'd1);
        chk("R9 no power-down yet", 64'(dn_cnt), 64'd0);
        open_win(); send_byte(8'h12); close_win();
        chk("R9 power-down pulse count", 64'(dn_cnt), 64'd1);
        open_win(); send_byte(8'h0B); send_byte(8'h0A); close_win();
        chk("R3 foreign ID power request ignored", 64'(up_cnt), 64'd1);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_ctrl_pairs();
        t_conf_pairs();
        t_wrong_id_unknown();
        t_abort();
        t_slots();
        t_power();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule